// File: doc/BRIEF.md
# T1-to-E1 G.802 Frame Mapper

This block carries a channelized T1 stream over a 2.048 MHz E1-timed link. It collects one T1 frame at a time and lays it out as a 32-slot, 256-bit E1 frame. Each T1 frame is a framing bit followed by channel octets: 24 octets in normal mode, or 23 octets when the ISDN layout is selected. The T1 octets fill E1 slots 1 to 15 and then continue from slot 17, so slot 0 and slot 16 are always skipped. The T1 framing bit lands in the first bit of the slot that follows the last filled slot. Every position that carries no T1 bit is sent as zero.

Both directions run on one system clock. Each direction has a bit-enable that marks the cycles carrying a bit, and a frame pulse that is qualified by that enable. T1 bits are written into one half of a two-frame store. A half is handed to the E1 side only after a whole T1 frame has been written into it, and the hand-over takes place at an E1 frame pulse. The E1 output therefore runs one frame behind the T1 input. If no finished frame is waiting at an E1 frame pulse, that E1 frame is sent as all zeros and a sticky underrun flag is raised.

Top module: `t1e1_g802_mapper`

## Requirements
- R1: With `isdn_mode_i`=0 latched, T1 octet k (1..15) appears in E1 slot k and octet k (16..24) in slot k+1. Each octet is sent MSB first, and the MSB is the first bit after the frame pulse.
- R2: With `isdn_mode_i`=1 latched, the frame has 23 octets. Octet k (1..15) goes to slot k and octet k (16..23) to slot k+1, MSB first.
- R3: The T1 framing bit (the bit sent with `t1_fp_i`) is output as the first bit of slot 26 in normal mode and of slot 25 in ISDN mode. The other seven bits of that slot are 0.
- R4: Slot 0, slot 16 and every slot after the framing-bit slot, up to slot 31, are output as 0.
- R5: `e1_bit_o` is registered. It changes only on the clock edge that ends a cycle with `e1_en_i`=1, and it holds its value otherwise. A T1 frame completed before an E1 frame pulse is sent during the E1 frame that the pulse starts, and E1 bit position 0 is the cycle where `e1_fp_i` is high.
- R6: If no completed T1 frame is waiting when an E1 frame pulse arrives, the whole E1 frame is output as zeros and `underrun_o` goes to 1. It stays at 1 until reset.
- R7: Each completed T1 frame is output in exactly one E1 frame. An E1 frame pulse with no new frame completed since the previous pulse yields an all-zero frame.
- R8: The mode is sampled only in the frame-pulse cycle of a T1 frame. A change of `isdn_mode_i` during the frame does not change that frame's layout.
- R9: A T1 frame pulse that arrives before the current T1 frame is complete discards the partial frame. Only the frame that starts at the new pulse can be output.
- R10: If a second T1 frame starts before the E1 side has taken a waiting frame, the waiting frame is dropped. The E1 side then outputs the newer frame once it is complete.
- R11: During and after reset, `e1_bit_o`=0 and `underrun_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for both directions |
| rst | input | 1 | Synchronous reset, active high |
| isdn_mode_i | input | 1 | Layout select: 0 = 24-octet T1, 1 = 23-octet ISDN T1 |
| t1_en_i | input | 1 | T1 bit-enable, high for one cycle per T1 bit |
| t1_fp_i | input | 1 | T1 frame pulse, marks the framing bit (valid with t1_en_i) |
| t1_bit_i | input | 1 | T1 serial data |
| e1_en_i | input | 1 | E1 bit-enable, high for one cycle per E1 bit |
| e1_fp_i | input | 1 | E1 frame pulse, marks bit 0 of slot 0 (valid with e1_en_i) |
| e1_bit_o | output | 1 | E1 serial data, registered |
| underrun_o | output | 1 | Sticky flag: an E1 frame started with no T1 frame waiting |

## Verification
The assertions assume that frame pulses are seen only when their enable is high. They also assume that an E1 frame pulse never falls in the same cycle as the last bit of a T1 frame, because a frame that completes in that cycle counts as late. Between a completed T1 frame and the next T1 frame pulse, the bank logic may hold a waiting frame only while the writer is idle. The stimulus keeps to these assumptions by running T1 frames and E1 frames in separate phases. It also varies the spacing between enables, so that every boundary takes place with both enables held low in between.

// File: rtl/g802_pkg.sv
package g802_pkg;
  localparam int SLOT_W        = 8;
  localparam int E1_SLOTS      = 32;
  localparam int E1_BITS       = E1_SLOTS * SLOT_W;
  localparam int POS_W         = $clog2(E1_BITS);
  localparam int SLOT_IDX_W    = $clog2(E1_SLOTS);
  localparam int T1_OCT_NORM   = 24;
  localparam int T1_OCT_ISDN   = 23;
  localparam int T1_BITS_NORM  = 1 + T1_OCT_NORM * SLOT_W;
  localparam int T1_BITS_ISDN  = 1 + T1_OCT_ISDN * SLOT_W;
  localparam int IDX_W         = $clog2(T1_BITS_NORM);
  localparam int LOW_SLOTS     = 15;
  localparam int SIG_SLOT      = LOW_SLOTS + 1;
  localparam int FSLOT_NORM    = T1_OCT_NORM + 2;
  localparam int FSLOT_ISDN    = T1_OCT_ISDN + 2;
  localparam int NUM_BANKS     = 2;
  localparam int BANK_W        = $clog2(NUM_BANKS);
endpackage

// File: rtl/g802_frame_ram.sv
module g802_frame_ram #(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic              wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic              rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/g802_t1_writer.sv
module g802_t1_writer
  import g802_pkg::*;
#(
  parameter int W_IDX     = IDX_W,
  parameter int BITS_NORM = T1_BITS_NORM,
  parameter int BITS_ISDN = T1_BITS_ISDN
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             t1_en,
  input  logic             t1_fp,
  input  logic             t1_bit,
  input  logic             isdn_sel,
  output logic             start_o,
  output logic             we_o,
  output logic [W_IDX-1:0] widx_o,
  output logic             wbit_o,
  output logic             done_o,
  output logic             frame_isdn_o,
  output logic             active_o
);
  localparam logic [W_IDX-1:0] LAST_NORM = W_IDX'(BITS_NORM - 1);
  localparam logic [W_IDX-1:0] LAST_ISDN = W_IDX'(BITS_ISDN - 1);

  logic             active_q;
  logic [W_IDX-1:0] idx_q;
  logic             isdn_q;
  logic [W_IDX-1:0] last_idx;
  logic             step;

  assign last_idx = isdn_q ? LAST_ISDN : LAST_NORM;
  assign start_o  = t1_en & t1_fp;
  assign step     = t1_en & ~t1_fp & active_q;
  assign we_o     = start_o | step;
  assign widx_o   = start_o ? '0 : idx_q;
  assign wbit_o   = t1_bit;
  assign done_o   = step & (idx_q == last_idx);
  assign frame_isdn_o = isdn_q;
  assign active_o = active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      isdn_q   <= 1'b0;
    end else if (start_o) begin
      active_q <= 1'b1;
      idx_q    <= W_IDX'(1);
      isdn_q   <= isdn_sel;
    end else if (step) begin
      if (done_o) begin
        active_q <= 1'b0;
        idx_q    <= '0;
      end else begin
        idx_q    <= idx_q + 1'b1;
      end
    end
  end

  // R1 R2: bit counter never runs beyond the last bit of the latched layout
  p_idx_bound_r1: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (idx_q <= last_idx));

  // R8: latched layout only moves at a frame pulse
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !start_o |=> (isdn_q == $past(isdn_q)));

  // R9: a new pulse always restarts the count just after the framing bit
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start_o |=> (active_q && idx_q == W_IDX'(1)));
endmodule

// File: rtl/g802_bank_ctrl.sv
module g802_bank_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic t1_start,
  input  logic t1_done,
  input  logic done_isdn,
  input  logic wr_active,
  input  logic e1_frame,
  output logic wr_sel_o,
  output logic rd_bank_o,
  output logic rd_valid_o,
  output logic rd_isdn_o,
  output logic underrun_o
);
  logic       rd_q;
  logic       wr_q;
  logic       pend_q;
  logic       valid_q;
  logic       under_q;
  logic [1:0] bank_isdn_q;
  logic       take;
  logic       rd_nxt;

  assign take     = e1_frame & pend_q;
  assign rd_nxt   = take ? ~rd_q : rd_q;
  assign wr_sel_o = t1_start ? ~rd_nxt : wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q        <= 1'b0;
      wr_q        <= 1'b1;
      pend_q      <= 1'b0;
      valid_q     <= 1'b0;
      under_q     <= 1'b0;
      bank_isdn_q <= '0;
    end else begin
      rd_q <= rd_nxt;
      if (t1_start) wr_q <= ~rd_nxt;
      if (t1_done) begin
        pend_q            <= 1'b1;
        bank_isdn_q[wr_q] <= done_isdn;
      end else if (take || t1_start) begin
        pend_q <= 1'b0;
      end
      if (e1_frame) begin
        valid_q <= take;
        if (!pend_q) under_q <= 1'b1;
      end
    end
  end

  assign rd_bank_o  = rd_q;
  assign rd_valid_o = valid_q;
  assign rd_isdn_o  = bank_isdn_q[rd_q];
  assign underrun_o = under_q;

  // R10: a waiting frame only exists while the writer is idle
  p_pend_idle_r10: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> !wr_active);

  // R7: taking a frame swaps banks and consumes it
  p_take_swap_r7: assert property (@(posedge clk) disable iff (rst)
    take |=> (rd_q != $past(rd_q)) && !pend_q && valid_q);

  // R6: a starved frame boundary raises underrun and blanks the frame
  p_starve_r6: assert property (@(posedge clk) disable iff (rst)
    (e1_frame && !pend_q) |=> (under_q && !valid_q));

  // R6: underrun is sticky
  p_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    under_q |=> under_q);
endmodule

// File: rtl/g802_e1_reader.sv
module g802_e1_reader
  import g802_pkg::*;
#(
  parameter int W_POS  = POS_W,
  parameter int W_IDX  = IDX_W,
  parameter int W_SLOT = SLOT_IDX_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             e1_en,
  input  logic             e1_fp,
  input  logic             rd_valid,
  input  logic             rd_isdn,
  input  logic             rdata,
  output logic [W_IDX-1:0] ridx_o,
  output logic             e1_bit_o
);
  localparam int               SB_W     = W_POS - W_SLOT;
  localparam logic [W_SLOT-1:0] LOW_LAST = W_SLOT'(LOW_SLOTS);
  localparam logic [W_SLOT-1:0] SIG      = W_SLOT'(SIG_SLOT);
  localparam logic [W_SLOT-1:0] FS_NORM  = W_SLOT'(FSLOT_NORM);
  localparam logic [W_SLOT-1:0] FS_ISDN  = W_SLOT'(FSLOT_ISDN);
  localparam logic [W_POS-1:0]  OFF_LO   = W_POS'(SLOT_W - 1);
  localparam logic [W_POS-1:0]  OFF_HI   = W_POS'(2 * SLOT_W - 1);

  logic [W_POS-1:0]  pos_q;
  logic [W_POS-1:0]  pos_nxt;
  logic [W_SLOT-1:0] slot;
  logic [SB_W-1:0]   sbit;
  logic [W_SLOT-1:0] fslot;
  logic              hit;
  logic [W_POS-1:0]  t1_pos;
  logic              bit_q;

  assign pos_nxt = e1_fp ? '0 : pos_q + 1'b1;
  assign slot    = pos_nxt[W_POS-1:SB_W];
  assign sbit    = pos_nxt[SB_W-1:0];
  assign fslot   = rd_isdn ? FS_ISDN : FS_NORM;

  always_comb begin
    hit    = 1'b0;
    t1_pos = '0;
    if (slot != '0 && slot <= LOW_LAST) begin
      hit    = 1'b1;
      t1_pos = pos_nxt - OFF_LO;
    end else if (slot > SIG && slot < fslot) begin
      hit    = 1'b1;
      t1_pos = pos_nxt - OFF_HI;
    end else if (slot == fslot && sbit == '0) begin
      hit    = 1'b1;
      t1_pos = '0;
    end
  end

  assign ridx_o = W_IDX'(t1_pos);

  always_ff @(posedge clk) begin
    if (rst) begin
      pos_q <= '0;
      bit_q <= 1'b0;
    end else if (e1_en) begin
      pos_q <= pos_nxt;
      bit_q <= (rd_valid && hit) ? rdata : 1'b0;
    end
  end

  assign e1_bit_o = bit_q;

  // R4: fixed empty slots always come out as zero
  p_fixed_zero_r4: assert property (@(posedge clk) disable iff (rst)
    (e1_en && (slot == '0 || slot == SIG || slot > fslot)) |=> !bit_q);

  // R6: a frame with no bank behind it is all zero
  p_empty_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (e1_en && !rd_valid) |=> !bit_q);

  // R5: output holds while the E1 enable is low
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !e1_en |=> $stable(bit_q));

  // R5: position restarts at every frame pulse
  p_pos_sync_r5: assert property (@(posedge clk) disable iff (rst)
    (e1_en && e1_fp) |=> (pos_q == '0));
endmodule

// File: rtl/t1e1_g802_mapper.sv
module t1e1_g802_mapper
  import g802_pkg::*;
#(
  parameter int W_IDX = IDX_W,
  parameter int W_POS = POS_W
) (
  input  logic clk,
  input  logic rst,
  input  logic isdn_mode_i,
  input  logic t1_en_i,
  input  logic t1_fp_i,
  input  logic t1_bit_i,
  input  logic e1_en_i,
  input  logic e1_fp_i,
  output logic e1_bit_o,
  output logic underrun_o
);
  localparam int ADDR_W = W_IDX + BANK_W;

  logic             t1_start;
  logic             t1_we;
  logic [W_IDX-1:0] t1_widx;
  logic             t1_wbit;
  logic             t1_done;
  logic             t1_isdn;
  logic             t1_active;
  logic             wr_sel;
  logic             rd_bank;
  logic             rd_valid;
  logic             rd_isdn;
  logic [W_IDX-1:0] rd_idx;
  logic             ram_q;
  logic             e1_frame;

  assign e1_frame = e1_en_i & e1_fp_i;

  g802_t1_writer #(.W_IDX(W_IDX)) u_writer (
    .clk          (clk),
    .rst          (rst),
    .t1_en        (t1_en_i),
    .t1_fp        (t1_fp_i),
    .t1_bit       (t1_bit_i),
    .isdn_sel     (isdn_mode_i),
    .start_o      (t1_start),
    .we_o         (t1_we),
    .widx_o       (t1_widx),
    .wbit_o       (t1_wbit),
    .done_o       (t1_done),
    .frame_isdn_o (t1_isdn),
    .active_o     (t1_active)
  );

  g802_bank_ctrl u_banks (
    .clk        (clk),
    .rst        (rst),
    .t1_start   (t1_start),
    .t1_done    (t1_done),
    .done_isdn  (t1_isdn),
    .wr_active  (t1_active),
    .e1_frame   (e1_frame),
    .wr_sel_o   (wr_sel),
    .rd_bank_o  (rd_bank),
    .rd_valid_o (rd_valid),
    .rd_isdn_o  (rd_isdn),
    .underrun_o (underrun_o)
  );

  g802_frame_ram #(.ADDR_W(ADDR_W)) u_ram (
    .clk   (clk),
    .we    (t1_we),
    .waddr ({wr_sel, t1_widx}),
    .wdata (t1_wbit),
    .raddr ({rd_bank, rd_idx}),
    .rdata (ram_q)
  );

  g802_e1_reader #(.W_POS(W_POS), .W_IDX(W_IDX)) u_reader (
    .clk      (clk),
    .rst      (rst),
    .e1_en    (e1_en_i),
    .e1_fp    (e1_fp_i),
    .rd_valid (rd_valid),
    .rd_isdn  (rd_isdn),
    .rdata    (ram_q),
    .ridx_o   (rd_idx),
    .e1_bit_o (e1_bit_o)
  );

  // R5 R10: the bank being written never coincides with the bank being read mid-frame
  p_bank_split_r5: assert property (@(posedge clk) disable iff (rst)
    (t1_we && !t1_start && rd_valid) |-> (wr_sel != rd_bank));

  // R11: outputs are quiet in the first cycle after reset
  p_reset_quiet_r11: assert property (@(posedge clk)
    $past(rst) |-> (!e1_bit_o && !underrun_o));
endmodule

// File: tb/test_t1e1_g802_mapper.sv
`timescale 1ns/1ps
module test_t1e1_g802_mapper;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic isdn_mode_i = 1'b0;
  logic t1_en_i = 1'b0, t1_fp_i = 1'b0, t1_bit_i = 1'b0;
  logic e1_en_i = 1'b0, e1_fp_i = 1'b0;
  logic e1_bit_o, underrun_o;

  int nchk = 0;
  int nfail = 0;

  logic [7:0]   oct [1:24];
  logic         fbit;
  logic [255:0] got;
  logic [255:0] expv;
  logic [255:0] m_data, m_fr, m_zero;
  int           hold_bad;

  always #2.5 clk = ~clk;

  t1e1_g802_mapper i_t1e1_g802_mapper (
    .clk(clk), .rst(rst), .isdn_mode_i(isdn_mode_i),
    .t1_en_i(t1_en_i), .t1_fp_i(t1_fp_i), .t1_bit_i(t1_bit_i),
    .e1_en_i(e1_en_i), .e1_fp_i(e1_fp_i),
    .e1_bit_o(e1_bit_o), .underrun_o(underrun_o)
  );

  task automatic check(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fill(input int seed, input bit fb);
    for (int k = 1; k <= 24; k++) oct[k] = 8'((k * 29 + seed * 53 + 7) ^ (seed << 3));
    fbit = fb;
  endtask

  function automatic logic t1_stream(input int i);
    if (i == 0) return fbit;
    return oct[(i - 1) / 8 + 1][7 - ((i - 1) % 8)];
  endfunction

  task automatic build_exp(input bit isdn);
    int top = isdn ? 24 : 25;
    int fs  = isdn ? 25 : 26;
    expv = '0; m_data = '0; m_fr = '0; m_zero = '0;
    for (int s = 0; s < 32; s++) begin
      for (int b = 0; b < 8; b++) begin
        int p = s * 8 + b;
        if (s >= 1 && s <= 15) begin
          m_data[p] = 1'b1; expv[p] = oct[s][7 - b];
        end else if (s >= 17 && s <= top) begin
          m_data[p] = 1'b1; expv[p] = oct[s - 1][7 - b];
        end else if (s == fs && b == 0) begin
          m_fr[p] = 1'b1; expv[p] = fbit;
        end else begin
          m_zero[p] = 1'b1;
        end
      end
    end
  endtask

  task automatic send_t1(input bit isdn, input int nbits, input int gap, input bit flip);
    isdn_mode_i = isdn;
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      t1_en_i = 1'b1; t1_fp_i = (i == 0); t1_bit_i = t1_stream(i);
      if (flip && i == 5) isdn_mode_i = ~isdn;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        t1_en_i = 1'b0; t1_fp_i = 1'b0;
      end
    end
    @(negedge clk);
    t1_en_i = 1'b0; t1_fp_i = 1'b0; isdn_mode_i = isdn;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_e1(input int gap);
    hold_bad = 0;
    for (int p = 0; p < 256; p++) begin
      @(negedge clk);
      e1_en_i = 1'b1; e1_fp_i = (p == 0);
      @(negedge clk);
      e1_en_i = 1'b0; e1_fp_i = 1'b0;
      got[p] = e1_bit_o;
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        if (e1_bit_o !== got[p]) hold_bad++;
      end
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frame(input bit isdn, input string ctx);
    build_exp(isdn);
    check((got & m_data) === (expv & m_data),
          {ctx, (isdn ? " R2 data slots" : " R1 data slots")}, got & m_data, expv & m_data);
    check((got & m_fr) === (expv & m_fr), {ctx, " R3 framing bit"}, got & m_fr, expv & m_fr);
    check((got & m_zero) === '0, {ctx, " R4 zero slots"}, got & m_zero, '0);
    check(hold_bad == 0, {ctx, " R5 hold between enables"}, 256'(hold_bad), '0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R5 watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    check(e1_bit_o === 1'b0 && underrun_o === 1'b0, "R11 reset outputs",
          256'({e1_bit_o, underrun_o}), '0);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    check(e1_bit_o === 1'b0 && underrun_o === 1'b0, "R11 after reset",
          256'({e1_bit_o, underrun_o}), '0);

    // sweep of patterns, both layouts, both framing values, varied spacing
    for (int f = 0; f < 12; f++) begin
      bit isdn = f[0];
      fill(f, f[1]);
      if (f == 10) begin for (int k = 1; k <= 24; k++) oct[k] = 8'hFF; fbit = 1'b1; end
      if (f == 11) begin for (int k = 1; k <= 24; k++) oct[k] = 8'h80 >> (k % 8); end
      send_t1(isdn, isdn ? 185 : 193, f % 3, 1'b0);
      run_e1(f % 2);
      check_frame(isdn, $sformatf("frame %0d", f));
    end
    check(underrun_o === 1'b0, "R6 no underrun when fed", 256'(underrun_o), '0);

    // R8: mode input flips mid-frame; layout must follow the pulse-time value
    fill(21, 1'b1);
    send_t1(1'b0, 193, 1, 1'b1);
    run_e1(0);
    check_frame(1'b0, "R8 flip to isdn");
    fill(22, 1'b1);
    send_t1(1'b1, 185, 0, 1'b1);
    run_e1(0);
    check_frame(1'b1, "R8 flip to normal");

    // R9: partial frame abandoned by a new pulse
    fill(30, 1'b0);
    send_t1(1'b0, 70, 0, 1'b0);
    fill(31, 1'b1);
    send_t1(1'b0, 193, 0, 1'b0);
    run_e1(1);
    check_frame(1'b0, "R9 restart");

    // R10: newer frame replaces an unconsumed one
    fill(40, 1'b0);
    send_t1(1'b1, 185, 0, 1'b0);
    fill(41, 1'b1);
    send_t1(1'b0, 193, 0, 1'b0);
    run_e1(0);
    check_frame(1'b0, "R10 replace");
    check(underrun_o === 1'b0, "R10 no underrun", 256'(underrun_o), '0);

    // R7 R6: no new frame, E1 frame is blank and underrun latches
    run_e1(0);
    check(got === '0, "R7 R6 starved frame all zero", got, '0);
    check(underrun_o === 1'b1, "R6 underrun set", 256'(underrun_o), 256'(1));

    // R6: flag stays set, data path resumes
    fill(50, 1'b1);
    send_t1(1'b1, 185, 2, 1'b0);
    run_e1(0);
    check_frame(1'b1, "R6 resume");
    check(underrun_o === 1'b1, "R6 underrun sticky", 256'(underrun_o), 256'(1));

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule